// File: doc/BRIEF.md
# Processor sleep and wake-event controller

This block produces the power-management control signals of a small processor core. It holds a 32-bit control register with three live fields: a wake-on-pending-interrupt enable, a deep-sleep request and a sleep-after-exception-return enable. It accepts strobes for the two sleep requests: wait-for-event (WFE) and wait-for-interrupt (WFI). It drives a `sleeping` output that clock-gating logic outside the block can act on. It also drives a `deep_sleep` qualifier that tells the system the core clock may be stopped.

A one-bit event flag records every wake event, whether or not the core is waiting at that moment. The wake events are an external event pulse, a send-event strobe, and, when enabled, a new rise on any interrupt pending flag. A later WFE that finds the flag set consumes it and does not sleep. A WFE that finds the flag clear sleeps until the next wake event. A WFI sleeps until any interrupt is pending. When the sleep-after-return field is set, a return from handler to thread mode acts like a WFI.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: The control register resets to 0. Writes update only bit 4 (wake on pending rise), bit 2 (deep sleep) and bit 1 (sleep on exception return). Every other bit always reads 0. A write is visible on `reg_rdata` in the cycle after it is issued.
- R2: An `ext_event` or `sev_strobe` pulse sets the event flag even while the core is awake or sleeping in WFI. The flag stays set until a WFE consumes it.
- R3: A WFE issued while the event flag is set leaves `sleeping` low and clears the flag, so the next WFE sleeps.
- R4: A WFE issued while the event flag is clear, with no wake event in the same cycle, raises `sleeping` in the cycle after the request. `sleeping` stays high until a wake event arrives.
- R5: With bit 4 set, a 0-to-1 change of any `irq_pend` bit between two consecutive cycles is a wake event: it ends a WFE sleep, and while awake it sets the event flag. With bit 4 clear, pending rises are not wake events.
- R6: A wake event during a WFE sleep drops `sleeping` in the next cycle and leaves the event flag clear, so the following WFE sleeps.
- R7: A WFI raises `sleeping` in the next cycle. The sleep ends in the cycle after any `irq_pend` bit is high, whatever bit 4 holds. External and send-event pulses do not end a WFI sleep.
- R8: `deep_sleep` equals `sleeping` AND control bit 2, so it falls on wake.
- R9: With bit 1 set, an `exc_return` strobe while awake raises `sleeping` in the next cycle, and the sleep behaves as a WFI. With bit 1 clear, `exc_return` has no effect.
- R10: A wake event in the same cycle as a WFE request counts as a set event flag: the core stays awake and the flag ends clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read value |
| wfe_req | input | 1 | Wait-for-event request strobe |
| wfi_req | input | 1 | Wait-for-interrupt request strobe |
| sev_strobe | input | 1 | Send-event strobe |
| ext_event | input | 1 | External event pulse |
| irq_pend | input | NUM_IRQ | Per-interrupt pending flags |
| exc_return | input | 1 | Handler-to-thread return strobe |
| sleeping | output | 1 | Core is in a sleep state |
| deep_sleep | output | 1 | Core clock may be stopped (qualified by sleeping) |

## Verification
On every cycle, the assertions check that reserved register bits read zero and that `deep_sleep` never appears without `sleeping`. They check that every rise of `sleeping` follows a sleep request or an exception return. They also check that WFE sleeps end on events, that WFI sleeps end on pending flags, and that an exception return is ignored when its enable is clear. The event flag cannot be seen from the ports, so only the bench scenarios show what it stores. Each scenario fires events while awake or during WFI, then follows with a WFE, and shows whether the flag was set, consumed or left clear. The scenarios also sweep each interrupt line against both wake-on-pending settings.

// File: rtl/pwr_sleep_pkg.sv
// Shared definitions for the sleep controller: field positions of the
// control register, its writable mask, the sleep state encoding and the
// decoded control bits. Assumes a 32-bit register.
package pwr_sleep_pkg;

    localparam int CTRL_W         = 32;
    localparam int BIT_WAKE_PEND  = 4;
    localparam int BIT_DEEP       = 2;
    localparam int BIT_EXIT_SLEEP = 1;

    localparam logic [CTRL_W-1:0] CTRL_MASK =
        (CTRL_W'(1) << BIT_WAKE_PEND) |
        (CTRL_W'(1) << BIT_DEEP)      |
        (CTRL_W'(1) << BIT_EXIT_SLEEP);

    typedef enum logic [1:0] {
        PS_RUN      = 2'd0,
        PS_WAIT_EVT = 2'd1,
        PS_WAIT_IRQ = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic wake_on_pend;
        logic deep;
        logic exit_sleep;
    } ctrl_bits_t;

endpackage

// File: rtl/pwr_ctrl_reg.sv
// Control register. Holds only the writable fields, so reserved bits
// read zero and ignore writes. Assumes one write strobe per cycle and
// exposes the stored value directly as the read data.
module pwr_ctrl_reg
    import pwr_sleep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output ctrl_bits_t        ctrl
);

    logic [CTRL_W-1:0] ctrl_q;

    // Store the masked write data; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wdata & CTRL_MASK;
    end

    // Present the stored value and decode the live fields.
    always_comb begin
        rdata             = ctrl_q;
        ctrl.wake_on_pend = ctrl_q[BIT_WAKE_PEND];
        ctrl.deep         = ctrl_q[BIT_DEEP];
        ctrl.exit_sleep   = ctrl_q[BIT_EXIT_SLEEP];
    end

endmodule

// File: rtl/pwr_pend_edge.sv
// Pending-flag monitor. Keeps a registered copy of the pending vector
// and reports whether any line rose since the previous cycle, and
// whether any line is pending now. Assumes pending inputs are
// synchronous to clk. The copy resets to zero, so a line already high
// right after reset counts as a rise.
module pwr_pend_edge #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend,
    output logic               any_rise,
    output logic               any_pend
);

    logic [NUM_IRQ-1:0] pend_prev_q;
    logic [NUM_IRQ-1:0] rise_vec;

    // Keep last cycle's pending vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_prev_q <= '0;
        else
            pend_prev_q <= pend;
    end

    // Per-line rise detection.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_rise
        assign rise_vec[i] = pend[i] & ~pend_prev_q[i];
    end

    // Reduce to the two summary flags.
    always_comb begin
        any_rise = |rise_vec;
        any_pend = |pend;
    end

endmodule

// File: rtl/pwr_event_latch.sv
// One-bit event flag. A consume request clears it and takes priority
// over a set request in the same cycle. The consumer decides whether a
// same-cycle event has already been used up.
module pwr_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic consume,
    output logic evt_q
);

    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else if (consume)
            evt_q <= 1'b0;
        else if (set_evt)
            evt_q <= 1'b1;
    end

endmodule

// File: rtl/pwr_sleep_fsm.sv
// Sleep state machine. From RUN it accepts a WFE, a WFI, or an
// exception return with sleep-after-return enabled; WFE is evaluated
// first. A WFE sleep ends on a wake event, a WFI sleep ends on any
// pending line. Requests that arrive while asleep are ignored. It tells
// the event flag when to consume.
module pwr_sleep_fsm
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfe_req,
    input  logic       wfi_req,
    input  logic       exc_return,
    input  logic       exit_sleep,
    input  logic       wake_evt,
    input  logic       evt_q,
    input  logic       any_pend,
    output logic       consume,
    output pwr_state_e state
);

    pwr_state_e state_q;
    pwr_state_e state_d;

    // Next-state and consume decision.
    always_comb begin
        state_d = state_q;
        consume = 1'b0;
        unique case (state_q)
            PS_RUN: begin
                if (wfe_req) begin
                    if (evt_q || wake_evt)
                        consume = 1'b1;
                    else
                        state_d = PS_WAIT_EVT;
                end else if (wfi_req || (exc_return && exit_sleep)) begin
                    state_d = PS_WAIT_IRQ;
                end
            end
            PS_WAIT_EVT: begin
                if (wake_evt) begin
                    consume = 1'b1;
                    state_d = PS_RUN;
                end
            end
            PS_WAIT_IRQ: begin
                if (any_pend)
                    state_d = PS_RUN;
            end
            default: state_d = PS_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PS_RUN;
        else
            state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/pwr_sleep_ctrl.sv
// Top of the sleep and wake-event controller. Combines the control
// register, the pending-rise monitor, the event flag and the sleep
// state machine, and derives the sleeping and deep-sleep outputs.
// Assumes all strobes are single-cycle and synchronous to clk.
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               wfe_req,
    input  logic               wfi_req,
    input  logic               sev_strobe,
    input  logic               ext_event,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               exc_return,
    output logic               sleeping,
    output logic               deep_sleep
);

    ctrl_bits_t ctrl;
    logic       pend_rise;
    logic       any_pend;
    logic       wake_evt;
    logic       evt_q;
    logic       consume;
    pwr_state_e fsm_state;

    pwr_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    pwr_pend_edge #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (irq_pend),
        .any_rise (pend_rise),
        .any_pend (any_pend)
    );

    // Wake events: explicit events always, pending rises when enabled.
    always_comb begin
        wake_evt = ext_event | sev_strobe | (ctrl.wake_on_pend & pend_rise);
    end

    pwr_event_latch u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (wake_evt),
        .consume (consume),
        .evt_q   (evt_q)
    );

    pwr_sleep_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfe_req    (wfe_req),
        .wfi_req    (wfi_req),
        .exc_return (exc_return),
        .exit_sleep (ctrl.exit_sleep),
        .wake_evt   (wake_evt),
        .evt_q      (evt_q),
        .any_pend   (any_pend),
        .consume    (consume),
        .state      (fsm_state)
    );

    // Output decode from the registered state.
    always_comb begin
        sleeping   = (fsm_state != PS_RUN);
        deep_sleep = sleeping & ctrl.deep;
    end

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
// Checker for the sleep controller, attached to the top by bind.
module pwr_sleep_ctrl_chk
    import pwr_sleep_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wfe_req,
    input logic               wfi_req,
    input logic               sev_strobe,
    input logic               ext_event,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic               exc_return,
    input logic [31:0]        reg_rdata,
    input logic               sleeping,
    input logic               deep_sleep,
    input pwr_state_e         fsm_state
);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~CTRL_MASK) == '0);

    // R8
    deep_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> sleeping);

    // R4
    sleep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping) |-> $past(wfe_req || wfi_req || exc_return));

    // R6
    wfe_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_WAIT_EVT && (ext_event || sev_strobe)) |=> !sleeping);

    // R7
    wfi_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_WAIT_IRQ && (|irq_pend)) |=> !sleeping);

    // R7
    wfi_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && wfi_req && !wfe_req) |=> sleeping);

    // R9
    exit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && exc_return && !reg_rdata[BIT_EXIT_SLEEP] && !wfe_req && !wfi_req)
        |=> !sleeping);

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfe_req    (wfe_req),
    .wfi_req    (wfi_req),
    .sev_strobe (sev_strobe),
    .ext_event  (ext_event),
    .irq_pend   (irq_pend),
    .exc_return (exc_return),
    .reg_rdata  (reg_rdata),
    .sleeping   (sleeping),
    .deep_sleep (deep_sleep),
    .fsm_state  (fsm_state)
);

// File: tb/pwr_sleep_ctrl_bench.sv
module pwr_sleep_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            wfe_req = 1'b0;
    logic            wfi_req = 1'b0;
    logic            sev_strobe = 1'b0;
    logic            ext_event = 1'b0;
    logic [NIRQ-1:0] irq_pend = '0;
    logic            exc_return = 1'b0;
    logic            sleeping;
    logic            deep_sleep;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_sleep_ctrl #(.NUM_IRQ(NIRQ)) u_pwr_sleep_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .wfe_req    (wfe_req),
        .wfi_req    (wfi_req),
        .sev_strobe (sev_strobe),
        .ext_event  (ext_event),
        .irq_pend   (irq_pend),
        .exc_return (exc_return),
        .sleeping   (sleeping),
        .deep_sleep (deep_sleep)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] v);
        reg_wr_en = 1'b1; reg_wdata = v; tick(); reg_wr_en = 1'b0;
    endtask

    task automatic do_wfe();
        wfe_req = 1'b1; tick(); wfe_req = 1'b0;
    endtask

    task automatic do_wfi();
        wfi_req = 1'b1; tick(); wfi_req = 1'b0;
    endtask

    task automatic do_sev();
        sev_strobe = 1'b1; tick(); sev_strobe = 1'b0;
    endtask

    task automatic do_ext();
        ext_event = 1'b1; tick(); ext_event = 1'b0;
    endtask

    task automatic pend_pulse(int line);
        irq_pend[line] = 1'b1; tick(); irq_pend = '0; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 reset rdata", reg_rdata, 32'h0);
        chk("R4 reset sleeping", {31'b0, sleeping}, 32'h0);
        chk("R8 reset deep", {31'b0, deep_sleep}, 32'h0);

        // R1 single-bit write sweep
        for (int b = 0; b < 32; b++) begin
            wr(32'h1 << b);
            chk("R1 bit write", reg_rdata, (32'h1 << b) & 32'h16);
        end
        wr(32'hFFFF_FFFF);
        chk("R1 all ones", reg_rdata, 32'h16);
        wr(32'h0);
        chk("R1 clear", reg_rdata, 32'h0);

        // R4 / R6 WFE sleep and wake
        do_wfe();
        chk("R4 wfe sleeps", {31'b0, sleeping}, 32'h1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 wfe holds", {31'b0, sleeping}, 32'h1);
        end
        do_ext();
        chk("R6 ext wakes", {31'b0, sleeping}, 32'h0);
        do_wfe();
        chk("R6 flag clear after wake", {31'b0, sleeping}, 32'h1);
        do_sev();
        chk("R6 sev wakes", {31'b0, sleeping}, 32'h0);

        // R2 / R3 event captured while awake
        for (int src = 0; src < 2; src++) begin
            if (src == 0) do_ext(); else do_sev();
            tick(); tick();
            chk("R2 awake event kept", {31'b0, sleeping}, 32'h0);
            do_wfe();
            chk("R3 wfe with flag no sleep", {31'b0, sleeping}, 32'h0);
            do_wfe();
            chk("R3 flag consumed", {31'b0, sleeping}, 32'h1);
            do_sev();
            chk("R6 wake", {31'b0, sleeping}, 32'h0);
        end

        // R10 same-cycle event with WFE
        wfe_req = 1'b1; ext_event = 1'b1; tick(); wfe_req = 1'b0; ext_event = 1'b0;
        chk("R10 same-cycle event", {31'b0, sleeping}, 32'h0);
        do_wfe();
        chk("R10 flag ends clear", {31'b0, sleeping}, 32'h1);
        do_sev();

        // R5 pending rise sweep for both wake-on-pend settings
        for (int wop = 0; wop < 2; wop++) begin
            wr(32'(wop) << 4);
            for (int i = 0; i < NIRQ; i++) begin
                do_wfe();
                chk("R5 enter wfe", {31'b0, sleeping}, 32'h1);
                irq_pend[i] = 1'b1; tick();
                chk("R5 pend rise wake", {31'b0, sleeping}, 32'(wop == 0));
                irq_pend = '0; tick();
                if (sleeping) do_sev();
                chk("R5 awake again", {31'b0, sleeping}, 32'h0);
            end
            pend_pulse(0);
            do_wfe();
            chk("R5 awake pend rise sets flag", {31'b0, sleeping}, 32'(wop == 0));
            if (sleeping) do_sev();
        end

        // R7 WFI sweep: events ignored, any pending line wakes
        for (int wop = 0; wop < 2; wop++) begin
            wr(32'(wop) << 4);
            for (int i = 0; i < NIRQ; i++) begin
                do_wfi();
                chk("R7 wfi sleeps", {31'b0, sleeping}, 32'h1);
                do_ext();
                chk("R7 event ignored in wfi", {31'b0, sleeping}, 32'h1);
                irq_pend[i] = 1'b1; tick();
                chk("R7 pend wakes wfi", {31'b0, sleeping}, 32'h0);
                irq_pend = '0; tick();
                do_wfe();
                chk("R2 event during wfi kept", {31'b0, sleeping}, 32'h0);
            end
        end
        wr(32'h0);

        // R8 deep sleep for both sleep kinds
        for (int dp = 0; dp < 2; dp++) begin
            wr(32'(dp) << 2);
            for (int m = 0; m < 2; m++) begin
                chk("R8 deep low awake", {31'b0, deep_sleep}, 32'h0);
                if (m == 0) do_wfe(); else do_wfi();
                chk("R8 deep while sleeping", {31'b0, deep_sleep}, 32'(dp));
                if (m == 1 && dp == 1) begin
                    wr(32'h0);
                    chk("R8 deep follows bit", {31'b0, deep_sleep}, 32'h0);
                    wr(32'h4);
                    chk("R8 deep follows bit set", {31'b0, deep_sleep}, 32'h1);
                end
                if (m == 0) do_sev();
                else begin
                    irq_pend[0] = 1'b1; tick(); irq_pend = '0;
                end
                chk("R8 deep drops on wake", {31'b0, deep_sleep}, 32'h0);
                tick();
            end
        end

        // R9 sleep after exception return
        for (int se = 0; se < 2; se++) begin
            wr(32'(se) << 1);
            exc_return = 1'b1; tick(); exc_return = 1'b0;
            chk("R9 exc return", {31'b0, sleeping}, 32'(se));
            if (se == 1) begin
                do_ext();
                chk("R9 behaves as wfi", {31'b0, sleeping}, 32'h1);
                irq_pend[1] = 1'b1; tick(); irq_pend = '0;
                chk("R9 pend wakes", {31'b0, sleeping}, 32'h0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule